// File: doc/BRIEF.md
# Adaptive Route Selection for a Flattened-Butterfly Router

This unit computes the route for one router of a two-dimensional flattened-butterfly on-chip network. The routers sit on a square grid. Each router serves four local terminals and has a direct link to every other router in its row and to every other router in its column, so any destination is at most two router-to-router hops away. The unit looks at each head flit and picks the output port and the virtual channel class. Body and tail flits then follow the head on the same port and channel.

A fresh packet, one injected at this router, is checked once. The unit weighs a minimal path against a non-minimal path through a randomly chosen intermediate router. Each hop count is multiplied by the occupancy estimate of the first-hop output queue on that path. The packet goes minimal when its cost is lower or equal. A packet sent non-minimally travels on VC0 toward its intermediate router. When it gets there, it moves to VC1 and finishes minimally. A packet on VC1 is never diverted again. Within each leg, the column (X) is corrected before the row (Y). Together with the two channel classes, this ordering prevents deadlock.

Top module: `fbfly_route_sel`

## Requirements
- R1: After reset, `rt_valid` is 0.
- R2: The output port is encoded as follows. Ports 0..3 are the local terminals. Ports 4..6 are the row links toward other columns, and ports 7..9 are the column links toward other rows. A link's index is the target coordinate if that is below the current one, and the target minus one otherwise. The queue depth of network port p sits at bits `[(p-4)*4 +: 4]` of `q_depth`.
- R3: A head flit routed minimally whose destination router is the current router leaves on the terminal port given by the low 2 bits of `in_dst`, on VC1. `in_dst` is packed as {y[1:0], x[1:0], terminal[1:0]}.
- R4: Minimal routing corrects X first, then Y.
- R5: For a fresh head flit, the unit computes two costs. The minimal cost is qmin×hmin and the non-minimal cost is qnm×hnm, where hnm counts the hops through the random router. The flit goes non-minimal only when qmin×hmin > qnm×hnm. A tie goes minimal. A non-minimal choice gives VC0 and sets `rt_mid` to the random router.
- R6: A fresh head flit whose random router is the current router is routed minimally, whatever the queue depths.
- R7: A non-fresh head flit on VC0 that is not at its intermediate router is routed toward that router, X first, on VC0, and `rt_mid` carries the intermediate router unchanged. This holds even when the current router is the destination.
- R8: A non-fresh head flit on VC0 that has reached its intermediate router is routed minimally to the destination on VC1.
- R9: A non-fresh head flit arriving on VC1 always leaves on VC1, along the minimal route.
- R10: Each accepted flit gives `rt_valid` one cycle later. Body and tail flits reuse the port and VC latched by their head, and their own fields are ignored. A tail flit closes the packet.
- R11: A body or tail flit that arrives when no packet is open produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Flit present |
| in_head | input | 1 | Flit is a head |
| in_tail | input | 1 | Flit is a tail (head and tail both set means a single-flit packet) |
| in_fresh | input | 1 | Packet was injected at this router |
| in_vc | input | 1 | Incoming channel class: 0 non-minimal leg, 1 minimal leg |
| in_mid_x | input | 2 | Intermediate router column from the header |
| in_mid_y | input | 2 | Intermediate router row from the header |
| in_dst | input | 6 | Destination {y, x, terminal} |
| cur_x | input | 2 | This router's column |
| cur_y | input | 2 | This router's row |
| rnd_x | input | 2 | Random intermediate column candidate |
| rnd_y | input | 2 | Random intermediate row candidate |
| q_depth | input | 24 | Occupancy estimate of each of the six network output queues |
| rt_valid | output | 1 | Route result valid |
| rt_port | output | 4 | Selected output port |
| rt_vc | output | 1 | Selected channel class |
| rt_mid_x | output | 2 | Intermediate column to write into the header |
| rt_mid_y | output | 2 | Intermediate row to write into the header |

## Verification
Two decisions can fall on the same fresh head flit. One is the queue-weighted comparison. The other is the guard against a random intermediate that equals the current router. The bench sets up this collision on purpose: the minimal first-hop queue is saturated, and the random router is the current one. Without the guard, the comparison would see a zero non-minimal cost and divert the packet. The bench expects the minimal port on VC1. It also sends weighted cases just above, at, and below the tie point, so that each side of the comparison is pinned down on its own.

// File: rtl/fbfly_route_sel.sv
module fbfly_route_sel #(
  parameter int CW = 2,
  parameter int TW = 2,
  parameter int QW = 4,
  localparam int NT = 1 << TW,
  localparam int K  = 1 << CW,
  localparam int NL = K - 1,
  localparam int NQ = 2 * NL,
  localparam int NP = NT + NQ,
  localparam int PW = $clog2(NP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_head,
  input  logic                 in_tail,
  input  logic                 in_fresh,
  input  logic                 in_vc,
  input  logic [CW-1:0]        in_mid_x,
  input  logic [CW-1:0]        in_mid_y,
  input  logic [2*CW+TW-1:0]   in_dst,
  input  logic [CW-1:0]        cur_x,
  input  logic [CW-1:0]        cur_y,
  input  logic [CW-1:0]        rnd_x,
  input  logic [CW-1:0]        rnd_y,
  input  logic [NQ*QW-1:0]     q_depth,
  output logic                 rt_valid,
  output logic [PW-1:0]        rt_port,
  output logic                 rt_vc,
  output logic [CW-1:0]        rt_mid_x,
  output logic [CW-1:0]        rt_mid_y
);
  localparam int CSW = QW + 3;

  function automatic logic [PW-1:0] link_port(input logic [CW-1:0] t, input logic [CW-1:0] c,
                                              input logic ydim);
    logic [CW-1:0] idx;
    idx = (t < c) ? t : t - 1'b1;
    return PW'(NT) + (ydim ? PW'(NL) : PW'(0)) + PW'(idx);
  endfunction

  function automatic logic [PW-1:0] step(input logic [CW-1:0] tx, input logic [CW-1:0] ty,
                                         input logic [TW-1:0] term);
    if (tx != cur_x)      return link_port(tx, cur_x, 1'b0);
    else if (ty != cur_y) return link_port(ty, cur_y, 1'b1);
    else                  return PW'(term);
  endfunction

  function automatic logic [1:0] hops(input logic [CW-1:0] ax, input logic [CW-1:0] ay,
                                      input logic [CW-1:0] bx, input logic [CW-1:0] by);
    return {1'b0, ax != bx} + {1'b0, ay != by};
  endfunction

  function automatic logic [QW-1:0] qof(input logic [PW-1:0] p);
    logic [QW-1:0] r;
    r = '0;
    for (int i = 0; i < NQ; i++)
      if (p == PW'(NT + i)) r = q_depth[i*QW +: QW];
    return r;
  endfunction

  logic [CW-1:0] dst_x, dst_y;
  logic [TW-1:0] dst_t;
  assign dst_t = in_dst[TW-1:0];
  assign dst_x = in_dst[TW +: CW];
  assign dst_y = in_dst[TW+CW +: CW];

  logic [PW-1:0] min_port, mid_port, rnd_port;
  assign min_port = step(dst_x, dst_y, dst_t);
  assign mid_port = step(in_mid_x, in_mid_y, '0);
  assign rnd_port = step(rnd_x, rnd_y, '0);

  logic at_mid, rnd_self;
  assign at_mid   = (in_mid_x == cur_x) && (in_mid_y == cur_y);
  assign rnd_self = (rnd_x == cur_x) && (rnd_y == cur_y);

  logic [CSW-1:0] cost_min, cost_nm;
  assign cost_min = CSW'(qof(min_port)) * CSW'(hops(cur_x, cur_y, dst_x, dst_y));
  assign cost_nm  = CSW'(qof(rnd_port)) *
                    (CSW'(hops(cur_x, cur_y, rnd_x, rnd_y)) + CSW'(hops(rnd_x, rnd_y, dst_x, dst_y)));

  logic go_nm;
  assign go_nm = in_fresh ? (!rnd_self && (cost_min > cost_nm)) : (!in_vc && !at_mid);

  logic busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rt_valid <= 1'b0;
      rt_port  <= '0;
      rt_vc    <= 1'b0;
      rt_mid_x <= '0;
      rt_mid_y <= '0;
      busy     <= 1'b0;
    end else if (in_valid && in_head) begin
      rt_valid <= 1'b1;
      rt_port  <= go_nm ? (in_fresh ? rnd_port : mid_port) : min_port;
      rt_vc    <= !go_nm;
      rt_mid_x <= (in_fresh && go_nm) ? rnd_x : in_mid_x;
      rt_mid_y <= (in_fresh && go_nm) ? rnd_y : in_mid_y;
      busy     <= !in_tail;
    end else if (in_valid && busy) begin
      rt_valid <= 1'b1;
      busy     <= !in_tail;
    end else begin
      rt_valid <= 1'b0;
    end
  end

  AST_PORT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |-> (rt_port < PW'(NP))); // R2
  AST_LOCAL_EJECT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_head && (in_fresh || in_vc || at_mid) && dst_x == cur_x && dst_y == cur_y
    |=> rt_port == PW'($past(dst_t)) && rt_vc); // R3
  AST_SELF_MID_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_head && in_fresh && rnd_self |=> rt_vc); // R6
  AST_NM_LEG_NETWORK: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && !rt_vc |-> rt_port >= PW'(NT)); // R7
  AST_VC1_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_head && !in_fresh && in_vc |=> rt_vc); // R9
  AST_BODY_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_head && busy |=> rt_valid && $stable(rt_port) && $stable(rt_vc)); // R10
  AST_ORPHAN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_head && !busy |=> !rt_valid); // R11
endmodule

// File: tb/fbfly_route_sel_test.sv
`timescale 1ns/1ps
module fbfly_route_sel_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_head = 0, in_tail = 0, in_fresh = 0, in_vc = 0;
  logic [1:0] in_mid_x = 0, in_mid_y = 0, cur_x = 2'd1, cur_y = 2'd2, rnd_x = 0, rnd_y = 0;
  logic [5:0] in_dst = 0;
  logic [23:0] q_depth = 0;
  logic rt_valid, rt_vc;
  logic [3:0] rt_port;
  logic [1:0] rt_mid_x, rt_mid_y;

  fbfly_route_sel uut (.*);

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic       vld;
    logic [3:0] port;
    logic       vc;
    logic [1:0] mx, my;
  } exp_t;

  exp_t    exp_q[$];
  string   req_q[$];
  realtime when_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [5:0] dst(input int x, input int y, input int t);
    return {2'(y), 2'(x), 2'(t)};
  endfunction

  function automatic logic [23:0] qv(input int ia, input int va, input int ib, input int vb);
    logic [23:0] r = '0;
    r[ia*4 +: 4] = 4'(va);
    r[ib*4 +: 4] = 4'(vb);
    return r;
  endfunction

  task automatic send(input logic h, input logic t, input logic fr, input logic vc,
                      input int mx, input int my, input logic [5:0] d, input int rx, input int ry,
                      input logic [23:0] q, input logic ev, input int ep, input logic evc,
                      input int emx, input int emy, input string req);
    @(negedge clk);
    in_valid = 1; in_head = h; in_tail = t; in_fresh = fr; in_vc = vc;
    in_mid_x = 2'(mx); in_mid_y = 2'(my); in_dst = d; rnd_x = 2'(rx); rnd_y = 2'(ry); q_depth = q;
    exp_q.push_back('{ev, 4'(ep), evc, 2'(emx), 2'(emy)});
    req_q.push_back(req);
    when_q.push_back($realtime);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_head = 0; in_tail = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0 && when_q[0] < $realtime) begin
        exp_t e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        void'(when_q.pop_front());
        checks++;
        if (rt_valid !== e.vld ||
            (e.vld && (rt_port !== e.port || rt_vc !== e.vc ||
                       (!e.vc && (rt_mid_x !== e.mx || rt_mid_y !== e.my))))) begin
          fails++;
          $display("FAIL %s: got valid=%0b port=%0d vc=%0b mid=(%0d,%0d) expected valid=%0b port=%0d vc=%0b mid=(%0d,%0d)",
                   r, rt_valid, rt_port, rt_vc, rt_mid_x, rt_mid_y, e.vld, e.port, e.vc, e.mx, e.my);
        end
      end else if (rt_valid) begin
        checks++; fails++;
        $display("FAIL R11: got unexpected valid=1 port=%0d expected valid=0", rt_port);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rt_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: got rt_valid=%0b expected 0", rt_valid);
    end
    rst_n = 1;
    // Router at (1,2). R3: local delivery to terminal 3
    send(1,1,1,0,0,0, dst(1,2,3), 3,3, 24'h0, 1, 3, 1, 0,0, "R3");
    // R4/R2: X first toward column 3 -> port 6; Y-only moves -> 7 and 9; column 0 -> 4
    send(1,1,0,1,0,0, dst(3,0,0), 0,0, 24'h0, 1, 6, 1, 0,0, "R4");
    send(1,1,0,1,0,0, dst(1,0,1), 0,0, 24'h0, 1, 7, 1, 0,0, "R4");
    send(1,1,0,1,0,0, dst(1,3,1), 0,0, 24'h0, 1, 9, 1, 0,0, "R2");
    send(1,1,0,1,0,0, dst(0,3,2), 0,0, 24'h0, 1, 4, 1, 0,0, "R2");
    // R5: dst (3,3) hmin=2 via port 6 (q idx 2); rnd (0,2) hnm=3 via port 4 (q idx 0)
    send(1,1,1,0,0,0, dst(3,3,0), 0,2, qv(2,9,0,5), 1, 4, 0, 0,2, "R5");
    send(1,1,1,0,0,0, dst(3,3,0), 0,2, qv(2,6,0,4), 1, 6, 1, 0,0, "R5");
    send(1,1,1,0,0,0, dst(3,3,0), 0,2, qv(2,6,0,5), 1, 6, 1, 0,0, "R5");
    // R6: random router is the current router while the minimal queue is full
    send(1,1,1,0,0,0, dst(3,3,0), 1,2, qv(2,15,0,0), 1, 6, 1, 0,0, "R6");
    // R9: minimal-leg packet ignores a full queue and a tempting random router
    send(1,1,0,1,0,2, dst(3,3,0), 0,2, qv(2,15,0,0), 1, 6, 1, 0,0, "R9");
    // R7: toward intermediate (1,0) -> port 7 on VC0; also while sitting at the destination
    send(1,1,0,0,1,0, dst(3,3,0), 0,0, 24'h0, 1, 7, 0, 1,0, "R7");
    send(1,1,0,0,3,2, dst(1,2,2), 0,0, 24'h0, 1, 6, 0, 3,2, "R7");
    // R8: at intermediate (1,2), finish minimally to (2,2) -> port 5 on VC1
    send(1,1,0,0,1,2, dst(2,2,0), 0,0, qv(1,15,0,0), 1, 5, 1, 0,0, "R8");
    // R10: head, body with other fields, tail reuse the head's port
    send(1,0,0,1,0,0, dst(3,0,0), 0,0, 24'h0, 1, 6, 1, 0,0, "R10");
    send(0,0,1,0,0,0, dst(1,2,1), 1,2, 24'h0, 1, 6, 1, 0,0, "R10");
    send(0,1,0,0,1,0, dst(0,0,0), 0,0, 24'h0, 1, 6, 1, 0,0, "R10");
    // R11: orphan body and orphan tail after the packet closed
    send(0,0,0,1,0,0, dst(1,2,0), 0,0, 24'h0, 0, 0, 0, 0,0, "R11");
    send(0,1,0,1,0,0, dst(1,2,0), 0,0, 24'h0, 0, 0, 0, 0,0, "R11");
    send(1,1,0,1,0,0, dst(1,2,2), 0,0, 24'h0, 1, 2, 1, 0,0, "R3");
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10: got %0d pending results expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule